// File: doc/BRIEF.md
# Bridge Interrupt Status Event Register

This block gathers asynchronous happenings inside a bus bridge into one memory-mapped status word. Each status bit is sticky: once an event sets it, it stays set until software writes a one to it. Three bits record single-cycle pulses from the bridge datapath: a failed write toward the PCI bus, a failed read from the PCI bus, and read data discarded because the PCI requester never came back for it. Three more bits are set by edges found inside the block. These are the rising and falling edges of the master-enable bit of the PCI command register, and the high-to-low edge of an active-low interrupt input line.

Software on the local side clears bits by writing ones to the status word at offset 0x3060. It selects which bits may interrupt through an enable word at offset 0x3070. The PCI-side copy of the status register can also clear the three datapath bits, through a separate clear strobe with its own bit mask. An event always beats a clear that arrives in the same cycle. The bridge operating mode and the presence of the non-prefetchable master port decide which bits exist at all. A bit that does not exist is held at zero. The interrupt output is a registered OR of every status bit whose enable bit is set.

Top module: `irq_event_status`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it, all status bits, all enable bits and the interrupt output read as zero.
- R2: A one-cycle pulse on the write-failure, read-failure or discard input sets status bit 0, bit 1 or bit 2 respectively, visible the next cycle. A set bit stays set until it is cleared.
- R3: A local write to offset 0x3060 clears every status bit whose data bit is 1. Bits written with 0 keep their value.
- R4: A PCI-side clear strobe clears status bits 0, 1 and 2, following its 3-bit mask (mask bit k clears status bit k). Bits 3 to 6 are never touched by it.
- R5: Status bit 3 sets when the master-enable input goes from 1 to 0. Status bit 4 sets when it goes from 0 to 1. Edges are found against the value registered on the previous clock.
- R6: Status bit 6 sets when the active-low interrupt input goes from 1 to 0. Its 0-to-1 edge has no effect.
- R7: When an event or edge for a bit occurs in the same cycle as any clear of that bit, the bit is 1 afterwards.
- R8: Bit 5 and bits 7 and up of both words always read 0, and writing ones to them changes nothing that can be read.
- R9: Bits 0, 1, 3 and 4 exist only in the peripheral and host modes. Bit 6 exists only in host mode. Bit 2 exists only when the non-prefetchable master port is present. Bits that do not exist read 0 even when their event fires.
- R10: The enable word at offset 0x3070 reads back what was written, limited to bits that exist. Reads from any other offset return 0.
- R11: The interrupt output equals, one clock later, the OR over all bits of status AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_addr | input | ADDR_W | Local-side register offset |
| loc_wr | input | 1 | Local-side write strobe |
| loc_wdata | input | DATA_W | Local-side write data |
| loc_rdata | output | DATA_W | Read data for loc_addr (combinational) |
| pci_clr_en | input | 1 | PCI-side clear strobe |
| pci_clr_mask | input | 3 | PCI-side clear mask for status bits 0 to 2 |
| ev_wr_fail | input | 1 | Pulse: write toward PCI failed |
| ev_rd_fail | input | 1 | Pulse: read from PCI failed |
| ev_np_discard | input | 1 | Pulse: non-prefetchable read data discarded |
| cmd_master_en | input | 1 | Master-enable bit of the PCI command register |
| irq_in_n | input | 1 | Active-low interrupt input line |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Several properties are checked on every cycle: the one-cycle latency of the interrupt output, that status bits stay set when no clear is applied, that a set wins over a clear, the edge-to-bit mapping for master-enable and the interrupt line, and that reserved bits read zero. Other behaviour can only be shown by the bench's scenarios, because it depends on chosen sequences of stimulus. This covers clear-by-write through each path with chosen masks, the ignored rising edge of the interrupt line, enable readback, and how a second instance built in peripheral mode without the non-prefetchable port drops its absent bits. The bench compares both instances against a behavioural model on every clock.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

    typedef enum logic [1:0] {
        BR_TARGET_ONLY = 2'd0,
        BR_PERIPH_MT   = 2'd1,
        BR_HOST        = 2'd2
    } bridge_mode_e;

    localparam int BIT_WR_FAIL  = 0;
    localparam int BIT_RD_FAIL  = 1;
    localparam int BIT_NP_DISC  = 2;
    localparam int BIT_ME_FALL  = 3;
    localparam int BIT_ME_RISE  = 4;
    localparam int BIT_IRQ_FALL = 6;
    localparam int NUM_EVT      = 7;
    localparam int PCI_CLR_W    = 3;

    // Which status bits exist for a mode / port configuration.
    function automatic logic [63:0] present_bits(bridge_mode_e mode, bit has_np);
        logic [63:0] b;
        b = '0;
        if (mode != BR_TARGET_ONLY) begin
            b[BIT_WR_FAIL] = 1'b1;
            b[BIT_RD_FAIL] = 1'b1;
            b[BIT_ME_FALL] = 1'b1;
            b[BIT_ME_RISE] = 1'b1;
        end
        if (mode == BR_HOST) begin
            b[BIT_IRQ_FALL] = 1'b1;
        end
        if (has_np) begin
            b[BIT_NP_DISC] = 1'b1;
        end
        return b;
    endfunction

endpackage

// File: rtl/evt_edge_det.sv
// Registers a level and flags any change against the previous clock.
module evt_edge_det #(
    parameter logic IDLE_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic toggled
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= IDLE_LVL;
        end else begin
            prev_q <= sig;
        end
    end

    assign toggled = sig ^ prev_q;
endmodule

// File: rtl/evt_sticky_bit.sv
// One write-one-to-clear status bit; a set in the same cycle as a clear wins.
module evt_sticky_bit #(
    parameter bit PRESENT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || !PRESENT) begin
            q <= 1'b0;
        end else begin
            q <= (q & ~clr) | set;
        end
    end
endmodule

// File: rtl/evt_csr_decode.sv
// Offset decode for the status and enable words.
module evt_csr_decode #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] STAT_OFS = 16'h3060,
    parameter logic [ADDR_W-1:0] MASK_OFS = 16'h3070
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              hit_stat,
    output logic              hit_mask,
    output logic              wr_stat,
    output logic              wr_mask
);
    always_comb begin
        hit_stat = (addr == STAT_OFS);
        hit_mask = (addr == MASK_OFS);
        wr_stat  = wr && hit_stat;
        wr_mask  = wr && hit_mask;
    end
endmodule

// File: rtl/irq_event_status.sv
module irq_event_status
    import irq_evt_pkg::*;
#(
    parameter int           ADDR_W        = 16,
    parameter int           DATA_W        = 32,
    parameter bridge_mode_e MODE          = BR_HOST,
    parameter bit           HAS_NP_MASTER = 1'b1,
    parameter logic [ADDR_W-1:0] STAT_OFS = 16'h3060,
    parameter logic [ADDR_W-1:0] MASK_OFS = 16'h3070
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic              loc_wr,
    input  logic [DATA_W-1:0] loc_wdata,
    output logic [DATA_W-1:0] loc_rdata,
    input  logic              pci_clr_en,
    input  logic [2:0]        pci_clr_mask,
    input  logic              ev_wr_fail,
    input  logic              ev_rd_fail,
    input  logic              ev_np_discard,
    input  logic              cmd_master_en,
    input  logic              irq_in_n,
    output logic              irq_out
);
    localparam logic [63:0]       IMPL_ALL  = present_bits(MODE, HAS_NP_MASTER);
    localparam logic [DATA_W-1:0] IMPL_MASK = IMPL_ALL[DATA_W-1:0];

    logic hit_stat, hit_mask, wr_stat, wr_mask;
    logic me_chg, irqn_chg;
    logic [NUM_EVT-1:0] raw_set, set_vec, clr_vec, stat_q;
    logic [DATA_W-1:0]  mask_q;
    logic               irq_q;

    evt_csr_decode #(
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS),
        .MASK_OFS (MASK_OFS)
    ) u_dec (
        .addr     (loc_addr),
        .wr       (loc_wr),
        .hit_stat (hit_stat),
        .hit_mask (hit_mask),
        .wr_stat  (wr_stat),
        .wr_mask  (wr_mask)
    );

    evt_edge_det #(.IDLE_LVL(1'b0)) u_me_edge (
        .clk     (clk),
        .rst     (rst),
        .sig     (cmd_master_en),
        .toggled (me_chg)
    );

    evt_edge_det #(.IDLE_LVL(1'b1)) u_irq_edge (
        .clk     (clk),
        .rst     (rst),
        .sig     (irq_in_n),
        .toggled (irqn_chg)
    );

    always_comb begin
        raw_set               = '0;
        raw_set[BIT_WR_FAIL]  = ev_wr_fail;
        raw_set[BIT_RD_FAIL]  = ev_rd_fail;
        raw_set[BIT_NP_DISC]  = ev_np_discard;
        raw_set[BIT_ME_FALL]  = me_chg & ~cmd_master_en;
        raw_set[BIT_ME_RISE]  = me_chg & cmd_master_en;
        raw_set[BIT_IRQ_FALL] = irqn_chg & ~irq_in_n;
        set_vec = raw_set & IMPL_MASK[NUM_EVT-1:0];
    end

    always_comb begin
        clr_vec = wr_stat ? loc_wdata[NUM_EVT-1:0] : '0;
        if (pci_clr_en) begin
            clr_vec[PCI_CLR_W-1:0] = clr_vec[PCI_CLR_W-1:0] | pci_clr_mask;
        end
    end

    for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_bit
        evt_sticky_bit #(.PRESENT(IMPL_MASK[gi])) u_bit (
            .clk (clk),
            .rst (rst),
            .set (set_vec[gi]),
            .clr (clr_vec[gi]),
            .q   (stat_q[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_mask) begin
            mask_q <= loc_wdata & IMPL_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(stat_q & mask_q[NUM_EVT-1:0]);
        end
    end

    always_comb begin
        loc_rdata = '0;
        if (hit_stat) begin
            loc_rdata[NUM_EVT-1:0] = stat_q;
        end else if (hit_mask) begin
            loc_rdata = mask_q;
        end
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/evt_status_checker.sv
module evt_status_checker #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 32,
    parameter int          NUM_EVT   = 7,
    parameter logic [DATA_W-1:0] IMPL_MASK = '1,
    parameter logic [ADDR_W-1:0] STAT_OFS  = 16'h3060
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] loc_addr,
    input logic [DATA_W-1:0] loc_rdata,
    input logic              pci_clr_en,
    input logic [2:0]        pci_clr_mask,
    input logic              cmd_master_en,
    input logic              irq_in_n,
    input logic              irq_out,
    input logic [NUM_EVT-1:0] stat,
    input logic [DATA_W-1:0] mask,
    input logic [NUM_EVT-1:0] set_vec,
    input logic [NUM_EVT-1:0] clr_vec
);
    localparam logic [DATA_W-1:0] RSVD = ~IMPL_MASK;

    AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (stat == '0 && irq_out == 1'b0)); // R1

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & $past(stat & ~clr_vec)) == $past(stat & ~clr_vec))); // R2

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((stat & $past(set_vec)) == $past(set_vec))); // R7

    AST_PCI_CLR_B0: assert property (@(posedge clk) disable iff (rst)
        (pci_clr_en && pci_clr_mask[0] && !set_vec[0]) |=> !stat[0]); // R4

    AST_ME_RISE: assert property (@(posedge clk) disable iff (rst)
        ($rose(cmd_master_en) && IMPL_MASK[4]) |=> stat[4]); // R5

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (rst)
        ($fell(irq_in_n) && IMPL_MASK[6]) |=> stat[6]); // R6

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (loc_addr == STAT_OFS) |-> ((loc_rdata & RSVD) == '0)); // R8

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_out == $past(|(stat & mask[NUM_EVT-1:0])))); // R11

endmodule

bind irq_event_status evt_status_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_EVT   (irq_evt_pkg::NUM_EVT),
    .IMPL_MASK (IMPL_MASK),
    .STAT_OFS  (STAT_OFS)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .loc_addr      (loc_addr),
    .loc_rdata     (loc_rdata),
    .pci_clr_en    (pci_clr_en),
    .pci_clr_mask  (pci_clr_mask),
    .cmd_master_en (cmd_master_en),
    .irq_in_n      (irq_in_n),
    .irq_out       (irq_out),
    .stat          (stat_q),
    .mask          (mask_q),
    .set_vec       (set_vec),
    .clr_vec       (clr_vec)
);

// File: tb/irq_event_status_bench.sv
`timescale 1ns/1ps
module irq_event_status_bench;
    localparam logic [15:0] STAT = 16'h3060;
    localparam logic [15:0] MASK = 16'h3070;
    localparam logic [31:0] IMPL_A = 32'h0000_005F; // host mode, NP port present
    localparam logic [31:0] IMPL_B = 32'h0000_001B; // peripheral mode, no NP port

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic [15:0] loc_addr = STAT;
    logic        loc_wr = 1'b0;
    logic [31:0] loc_wdata = '0;
    logic        pci_clr_en = 1'b0;
    logic [2:0]  pci_clr_mask = '0;
    logic        ev_wr_fail = 1'b0, ev_rd_fail = 1'b0, ev_np_discard = 1'b0;
    logic        cmd_master_en = 1'b0;
    logic        irq_in_n = 1'b1;
    logic [31:0] rd_a, rd_b;
    logic        irq_a, irq_b;

    irq_event_status u_irq_event_status (
        .clk(clk), .rst(rst), .loc_addr(loc_addr), .loc_wr(loc_wr), .loc_wdata(loc_wdata),
        .loc_rdata(rd_a), .pci_clr_en(pci_clr_en), .pci_clr_mask(pci_clr_mask),
        .ev_wr_fail(ev_wr_fail), .ev_rd_fail(ev_rd_fail), .ev_np_discard(ev_np_discard),
        .cmd_master_en(cmd_master_en), .irq_in_n(irq_in_n), .irq_out(irq_a)
    );

    irq_event_status #(.MODE(irq_evt_pkg::BR_PERIPH_MT), .HAS_NP_MASTER(1'b0)) u_irq_event_status_periph (
        .clk(clk), .rst(rst), .loc_addr(loc_addr), .loc_wr(loc_wr), .loc_wdata(loc_wdata),
        .loc_rdata(rd_b), .pci_clr_en(pci_clr_en), .pci_clr_mask(pci_clr_mask),
        .ev_wr_fail(ev_wr_fail), .ev_rd_fail(ev_rd_fail), .ev_np_discard(ev_np_discard),
        .cmd_master_en(cmd_master_en), .irq_in_n(irq_in_n), .irq_out(irq_b)
    );

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R1";

    logic [31:0] m_stat [2];
    logic [31:0] m_mask [2];
    logic        m_irq  [2];
    logic        m_prev_me = 1'b0;
    logic        m_prev_irqn = 1'b1;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        for (int i = 0; i < 2; i++) begin
            logic [31:0] impl, setv, clrv;
            impl = (i == 0) ? IMPL_A : IMPL_B;
            if (rst) begin
                m_stat[i] = '0; m_mask[i] = '0; m_irq[i] = 1'b0;
            end else begin
                setv = '0;
                setv[0] = ev_wr_fail;
                setv[1] = ev_rd_fail;
                setv[2] = ev_np_discard;
                setv[3] = m_prev_me && !cmd_master_en;
                setv[4] = !m_prev_me && cmd_master_en;
                setv[6] = m_prev_irqn && !irq_in_n;
                clrv = (loc_wr && loc_addr == STAT) ? loc_wdata : 32'h0;
                if (pci_clr_en) clrv = clrv | {29'h0, pci_clr_mask};
                m_irq[i] = (m_stat[i] & m_mask[i]) != 0;
                m_stat[i] = ((m_stat[i] & ~clrv) | setv) & impl;
                if (loc_wr && loc_addr == MASK) m_mask[i] = loc_wdata & impl;
            end
        end
        if (rst) begin
            m_prev_me = 1'b0; m_prev_irqn = 1'b1;
        end else begin
            m_prev_me = cmd_master_en; m_prev_irqn = irq_in_n;
        end
    endtask

    task automatic compare();
        for (int i = 0; i < 2; i++) begin
            logic [31:0] exp_rd;
            exp_rd = (loc_addr == STAT) ? m_stat[i] : (loc_addr == MASK) ? m_mask[i] : 32'h0;
            check(cur_req, (i == 0) ? "rdata host" : "rdata periph", (i == 0) ? rd_a : rd_b, exp_rd);
            check(cur_req, (i == 0) ? "irq host" : "irq periph",
                  {31'h0, (i == 0) ? irq_a : irq_b}, {31'h0, m_irq[i]});
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        loc_wr = 1'b0; loc_addr = STAT; loc_wdata = '0;
        pci_clr_en = 1'b0; pci_clr_mask = '0;
        ev_wr_fail = 1'b0; ev_rd_fail = 1'b0; ev_np_discard = 1'b0;
    endtask

    task automatic lwrite(logic [15:0] a, logic [31:0] d);
        loc_addr = a; loc_wdata = d; loc_wr = 1'b1;
        tick();
        idle();
    endtask

    initial begin
        #(200000 * 20);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            m_stat[i] = '0; m_mask[i] = '0; m_irq[i] = 1'b0;
        end
        @(negedge clk);
        // R1: reset state, and first cycle after release
        cur_req = "R1";
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1", "status after reset", rd_a, 32'h0);

        // R2: datapath pulses set sticky bits
        cur_req = "R2";
        ev_wr_fail = 1'b1; tick(); idle();
        ev_rd_fail = 1'b1; tick(); idle();
        ev_np_discard = 1'b1; tick(); idle();
        repeat (3) tick();
        check("R2", "three pulse bits held", rd_a, 32'h7);

        // R3: local write-one-to-clear
        cur_req = "R3";
        lwrite(STAT, 32'h1);
        check("R3", "bit0 cleared only", rd_a, 32'h6);
        lwrite(STAT, 32'h0);
        lwrite(STAT, 32'hFFFF_FFFF);
        check("R3", "all cleared", rd_a, 32'h0);

        // R4: PCI-side clear of bits 0..2 only
        cur_req = "R4";
        ev_wr_fail = 1'b1; ev_rd_fail = 1'b1; ev_np_discard = 1'b1; cmd_master_en = 1'b1;
        tick(); idle();
        pci_clr_en = 1'b1; pci_clr_mask = 3'b101; tick(); idle();
        check("R4", "mask 101 leaves bits 1 and 4", rd_a, 32'h12);
        pci_clr_en = 1'b1; pci_clr_mask = 3'b111; tick(); idle();
        check("R4", "edge bit untouched", rd_a, 32'h10);
        lwrite(STAT, 32'h7F);

        // R5: master-enable edges
        cur_req = "R5";
        cmd_master_en = 1'b0; tick();
        check("R5", "fall sets bit3", rd_a, 32'h08);
        cmd_master_en = 1'b1; tick();
        check("R5", "rise sets bit4", rd_a, 32'h18);
        tick();
        lwrite(STAT, 32'h18);

        // R6: interrupt line falling edge only
        cur_req = "R6";
        irq_in_n = 1'b0; tick(); tick();
        check("R6", "fall sets bit6", rd_a, 32'h40);
        lwrite(STAT, 32'h40);
        irq_in_n = 1'b1; tick(); tick();
        check("R6", "rise ignored", rd_a, 32'h0);

        // R7: event beats same-cycle clear, on both paths
        cur_req = "R7";
        ev_wr_fail = 1'b1; loc_addr = STAT; loc_wdata = 32'h1; loc_wr = 1'b1; tick(); idle();
        check("R7", "pulse vs local clear", rd_a, 32'h1);
        cmd_master_en = 1'b0; tick();
        cmd_master_en = 1'b1; loc_wdata = 32'h18; loc_wr = 1'b1; tick(); idle();
        check("R7", "rise vs clear keeps bit4", rd_a, 32'h11);
        ev_rd_fail = 1'b1; pci_clr_en = 1'b1; pci_clr_mask = 3'b010; tick(); idle();
        check("R7", "pulse vs PCI clear", rd_a, 32'h13);
        lwrite(STAT, 32'hFF);

        // R8: reserved bits
        cur_req = "R8";
        lwrite(STAT, 32'hFFFF_FFA0);
        check("R8", "reserved status zero", rd_a, 32'h0);
        lwrite(MASK, 32'hFFFF_FFFF);
        loc_addr = MASK; tick();
        check("R8", "reserved enable zero", rd_a & ~IMPL_A, 32'h0);

        // R10: enable readback, other offsets
        cur_req = "R10";
        check("R10", "enable host", rd_a, IMPL_A);
        check("R10", "enable periph", rd_b, IMPL_B);
        loc_addr = 16'h3064; tick();
        check("R10", "unmapped offset", rd_a, 32'h0);
        idle();
        lwrite(MASK, 32'h1);

        // R11: interrupt latency
        cur_req = "R11";
        ev_rd_fail = 1'b1; tick(); idle(); tick();
        check("R11", "masked bit no irq", {31'h0, irq_a}, 32'h0);
        ev_wr_fail = 1'b1; tick(); idle();
        check("R11", "irq not yet", {31'h0, irq_a}, 32'h0);
        tick();
        check("R11", "irq one cycle later", {31'h0, irq_a}, 32'h1);
        lwrite(STAT, 32'h1);
        tick();
        check("R11", "irq drops", {31'h0, irq_a}, 32'h0);
        lwrite(STAT, 32'hFF);

        // R9: absent bits in the peripheral instance
        cur_req = "R9";
        ev_np_discard = 1'b1; irq_in_n = 1'b0; tick(); idle(); tick();
        check("R9", "host has bits 2 and 6", rd_a, 32'h44);
        check("R9", "periph lacks bits 2 and 6", rd_b, 32'h0);
        irq_in_n = 1'b1;
        lwrite(STAT, 32'hFF);
        repeat (2) tick();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule